// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sequences the gate drive of one half-bridge leg. It takes a high-side and a low-side on-command and, for each gate, decides every cycle whether the strong or weak source path and the strong or weak sink path is enabled. Before any gate is sourced, it waits for the gate-voltage comparator of the opposite switch to report that gate as off. The dead time therefore follows the real gate discharge and is not a fixed delay. A handshake that never completes ends in a fault.

Each turn-on starts with a strong-source window whose length is programmable. During that window the opposite gate gets a strong sink, which drains charge coupled in while the switch node slews. At the end of the window the block checks the comparator of the driven gate. If it reports the gate as on, the block drops to a weak holding source and a weak pulldown on the other gate. If it does not, the block latches a gate fault and sinks both gates hard until software clears the fault. A current-level code for the analog source stage is registered and passed through unchanged.

Top module: `hb_gate_seq`

## Requirements
- R1: During and after reset, with no command, both gates have only their weak sink enabled, `fault` is 0 and `drv_level` is 0.
- R2: A lone command for one side enables no source on that side until the opposite monitor, seen through a two-flop synchronizer, reads 0. Until then that side keeps its weak sink and the opposite gate gets its strong sink.
- R3: The strong-source window lasts W = max(`win_len`,1) cycles. During it the commanded gate has only its strong source and the opposite gate has only its strong sink.
- R4: If the synchronized monitor of the driven gate reads 1 at the end of the window, the driven gate moves to its weak source and the opposite gate to its weak sink, and this holds while the command stays.
- R5: If that monitor reads 0 at the end of the window, `fault` rises. Both gates then have only their strong sink enabled.
- R6: If the opposite monitor still reads 1 after HS_MAX (1023) cycles of waiting, `fault` rises.
- R7: `fault` stays set whatever the commands and monitors do, until `fault_clr` is high in a cycle where both commands are low. The block then returns to the state of R1.
- R8: Both commands high at once is illegal. No source is enabled and both gates return to weak sink.
- R9: `drv_level` equals `drv_level_in` one clock later, at any time and in any state.
- R10: Dropping the command during the wait, window or hold returns both gates to weak sink on the next clock.
- R11: The two sources are never enabled together, and no gate has a source and a sink enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_hi | input | 1 | High-side on-command |
| on_lo | input | 1 | Low-side on-command |
| gate_up_hi | input | 1 | High-side gate comparator, 1 = above threshold (asynchronous) |
| gate_up_lo | input | 1 | Low-side gate comparator, 1 = above threshold (asynchronous) |
| win_len | input | 10 | Strong-drive window in clocks, 0 treated as 1 |
| drv_level_in | input | 3 | Source current level code |
| fault_clr | input | 1 | Fault clear, honoured only with both commands low |
| hi_src_strong | output | 1 | High-side strong source enable |
| hi_src_weak | output | 1 | High-side weak holding source enable |
| hi_snk_strong | output | 1 | High-side strong pulldown enable |
| hi_snk_weak | output | 1 | High-side weak pulldown enable |
| lo_src_strong | output | 1 | Low-side strong source enable |
| lo_src_weak | output | 1 | Low-side weak holding source enable |
| lo_snk_strong | output | 1 | Low-side strong pulldown enable |
| lo_snk_weak | output | 1 | Low-side weak pulldown enable |
| drv_level | output | 3 | Registered level code |
| fault | output | 1 | Latched gate-drive fault |

## Verification
A command sampled on a clock edge puts the block into its wait phase on that same edge. The strong window starts one edge later when the opposite monitor has long been low. A monitor change needs two edges to cross the synchronizer and acts on the third. The window's verdict lands W edges after the window began, and the handshake timeout lands on edge HS_MAX after the wait began. The bench drives inputs on the falling edge and advances an exact count of rising edges worked out from these latencies. It samples one time unit after the last edge and checks both sides of every boundary: the cycle before the window ends and the cycle after, and edge 1023 and edge 1024 of the handshake wait.

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int WIN_W  = 10,
  parameter int LVL_W  = 3,
  parameter int HS_MAX = 1023
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_hi,
  input  logic             on_lo,
  input  logic             gate_up_hi,
  input  logic             gate_up_lo,
  input  logic [WIN_W-1:0] win_len,
  input  logic [LVL_W-1:0] drv_level_in,
  input  logic             fault_clr,
  output logic             hi_src_strong,
  output logic             hi_src_weak,
  output logic             hi_snk_strong,
  output logic             hi_snk_weak,
  output logic             lo_src_strong,
  output logic             lo_src_weak,
  output logic             lo_snk_strong,
  output logic             lo_snk_weak,
  output logic [LVL_W-1:0] drv_level,
  output logic             fault
);
  localparam int HS_W = $clog2(HS_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_HI, S_DRV_HI, S_HOLD_HI,
    S_WAIT_LO, S_DRV_LO, S_HOLD_LO, S_FAULT
  } st_t;

  st_t              st;
  logic [1:0]       sy_hi, sy_lo;
  logic [WIN_W-1:0] win_cnt;
  logic [HS_W-1:0]  hs_cnt;
  logic [7:0]       drive;

  wire up_hi   = sy_hi[1];
  wire up_lo   = sy_lo[1];
  wire want_hi = on_hi & ~on_lo;
  wire want_lo = on_lo & ~on_hi;
  wire side_hi = (st == S_WAIT_HI) || (st == S_DRV_HI) || (st == S_HOLD_HI);
  wire side_lo = (st == S_WAIT_LO) || (st == S_DRV_LO) || (st == S_HOLD_LO);
  wire hs_last = (hs_cnt == HS_W'(HS_MAX - 1));
  wire [WIN_W-1:0] win_eff = (win_len == '0) ? WIN_W'(1) : win_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sy_hi     <= 2'b11;
      sy_lo     <= 2'b11;
      win_cnt   <= '0;
      hs_cnt    <= '0;
      drv_level <= '0;
    end else begin
      sy_hi     <= {sy_hi[0], gate_up_hi};
      sy_lo     <= {sy_lo[0], gate_up_lo};
      drv_level <= drv_level_in;
      if (st == S_FAULT) begin
        if (fault_clr && !on_hi && !on_lo) st <= S_IDLE;
      end else if (!want_hi && !want_lo) begin
        st <= S_IDLE;
      end else if (want_hi && !side_hi) begin
        st     <= S_WAIT_HI;
        hs_cnt <= '0;
      end else if (want_lo && !side_lo) begin
        st     <= S_WAIT_LO;
        hs_cnt <= '0;
      end else begin
        case (st)
          S_WAIT_HI, S_WAIT_LO: begin
            if (!((st == S_WAIT_HI) ? up_lo : up_hi)) begin
              st      <= (st == S_WAIT_HI) ? S_DRV_HI : S_DRV_LO;
              win_cnt <= win_eff;
            end else if (hs_last) begin
              st <= S_FAULT;
            end else begin
              hs_cnt <= hs_cnt + 1'b1;
            end
          end
          S_DRV_HI: begin
            if (win_cnt == WIN_W'(1)) st <= up_hi ? S_HOLD_HI : S_FAULT;
            else win_cnt <= win_cnt - 1'b1;
          end
          S_DRV_LO: begin
            if (win_cnt == WIN_W'(1)) st <= up_lo ? S_HOLD_LO : S_FAULT;
            else win_cnt <= win_cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_WAIT_HI: drive = 8'b0001_0010;
      S_DRV_HI:  drive = 8'b1000_0010;
      S_HOLD_HI: drive = 8'b0100_0001;
      S_WAIT_LO: drive = 8'b0010_0001;
      S_DRV_LO:  drive = 8'b0010_1000;
      S_HOLD_LO: drive = 8'b0001_0100;
      S_FAULT:   drive = 8'b0010_0010;
      default:   drive = 8'b0001_0001;
    endcase
  end

  assign {hi_src_strong, hi_src_weak, hi_snk_strong, hi_snk_weak,
          lo_src_strong, lo_src_weak, lo_snk_strong, lo_snk_weak} = drive;
  assign fault = (st == S_FAULT);
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic on_hi,
  input logic on_lo,
  input logic gate_up_hi,
  input logic gate_up_lo,
  input logic fault_clr,
  input logic hi_src_strong,
  input logic hi_src_weak,
  input logic hi_snk_strong,
  input logic hi_snk_weak,
  input logic lo_src_strong,
  input logic lo_src_weak,
  input logic lo_snk_strong,
  input logic lo_snk_weak,
  input logic fault
);
  wire hi_src = hi_src_strong | hi_src_weak;
  wire lo_src = lo_src_strong | lo_src_weak;
  wire hi_snk = hi_snk_strong | hi_snk_weak;
  wire lo_snk = lo_snk_strong | lo_snk_weak;

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n) !(hi_src && lo_src)); // R11
  AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hi_src && hi_snk) && !(lo_src && lo_snk)); // R11
  AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(hi_src_strong) |-> !$past(gate_up_lo, 3)); // R2
  AST_LO_AFTER_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(lo_src_strong) |-> !$past(gate_up_hi, 3)); // R2
  AST_FAULT_SAFE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> (hi_snk_strong && lo_snk_strong && !hi_src && !lo_src)); // R5
  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (fault && !(fault_clr && !on_hi && !on_lo)) |=> fault); // R7
  AST_ILLEGAL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (on_hi && on_lo) |=> (!hi_src && !lo_src)); // R8
  AST_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!on_hi && !on_lo && !fault) |=> (hi_snk_weak && lo_snk_weak)); // R10
endmodule

bind hb_gate_seq hb_gate_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .on_hi(on_hi), .on_lo(on_lo),
  .gate_up_hi(gate_up_hi), .gate_up_lo(gate_up_lo), .fault_clr(fault_clr),
  .hi_src_strong(hi_src_strong), .hi_src_weak(hi_src_weak),
  .hi_snk_strong(hi_snk_strong), .hi_snk_weak(hi_snk_weak),
  .lo_src_strong(lo_src_strong), .lo_src_weak(lo_src_weak),
  .lo_snk_strong(lo_snk_strong), .lo_snk_weak(lo_snk_weak),
  .fault(fault)
);

// File: tb/hb_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hb_gate_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic on_hi = 0, on_lo = 0, gate_up_hi = 0, gate_up_lo = 0, fault_clr = 0;
  logic [9:0] win_len = 10'd4;
  logic [2:0] drv_level_in = 0, drv_level;
  logic hss, hsw, hks, hkw, lss, lsw, lks, lkw, fault;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  hb_gate_seq dut_i (
    .clk(clk), .rst_n(rst_n), .on_hi(on_hi), .on_lo(on_lo),
    .gate_up_hi(gate_up_hi), .gate_up_lo(gate_up_lo), .win_len(win_len),
    .drv_level_in(drv_level_in), .fault_clr(fault_clr),
    .hi_src_strong(hss), .hi_src_weak(hsw), .hi_snk_strong(hks), .hi_snk_weak(hkw),
    .lo_src_strong(lss), .lo_src_weak(lsw), .lo_snk_strong(lks), .lo_snk_weak(lkw),
    .drv_level(drv_level), .fault(fault)
  );

  // word: {fault, hi src strong/weak, hi sink strong/weak, lo src strong/weak, lo sink strong/weak}
  localparam logic [8:0] W_IDLE = 9'h011, W_WAIT_HI = 9'h012, W_DRV_HI = 9'h082,
    W_HOLD_HI = 9'h041, W_WAIT_LO = 9'h021, W_DRV_LO = 9'h028, W_HOLD_LO = 9'h014,
    W_FAULT = 9'h122;

  // {on_hi, on_lo, up_hi, up_lo, clr, edges[2:0], req[3:0], expected[8:0]}
  localparam logic [20:0] VEC [13] = '{
    {5'b00000, 3'd1, 4'd1,  W_IDLE},     // R1 idle
    {5'b10000, 3'd1, 4'd2,  W_WAIT_HI},  // R2 wait phase
    {5'b10000, 3'd1, 4'd2,  W_DRV_HI},   // R2 opposite already off
    {5'b10100, 3'd2, 4'd3,  W_DRV_HI},   // R3 window still running
    {5'b10100, 3'd2, 4'd4,  W_HOLD_HI},  // R4 gate up at window end
    {5'b01100, 3'd1, 4'd2,  W_WAIT_LO},  // R2 swap side
    {5'b01100, 3'd3, 4'd2,  W_WAIT_LO},  // R2 high gate still up
    {5'b01000, 3'd2, 4'd2,  W_WAIT_LO},  // R2 synchronizer latency
    {5'b01000, 3'd1, 4'd2,  W_DRV_LO},   // R2 low drive starts
    {5'b01000, 3'd4, 4'd5,  W_FAULT},    // R5 low gate never rose
    {5'b01001, 3'd1, 4'd7,  W_FAULT},    // R7 clear ignored with command high
    {5'b00001, 3'd1, 4'd7,  W_IDLE},     // R7 clear honoured
    {5'b11000, 3'd2, 4'd8,  W_IDLE}      // R8 illegal pair
  };

  function automatic logic [8:0] outw();
    return {fault, hss, hsw, hks, hkw, lss, lsw, lks, lkw};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_in(input logic h, input logic l, input logic uh, input logic ul, input logic c);
    @(negedge clk);
    on_hi = h; on_lo = l; gate_up_hi = uh; gate_up_lo = ul; fault_clr = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    edges(2);
    chk("R1 reset outputs", outw(), W_IDLE);
    chk("R1 reset level", drv_level, 0);
    @(negedge clk); rst_n = 1;
    edges(3);

    foreach (VEC[i]) begin
      drive_in(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      edges(int'(VEC[i][15:13]));
      chk($sformatf("R%0d vector %0d", VEC[i][12:9], i), outw(), VEC[i][8:0]);
    end

    // R3 zero window acts as one cycle
    win_len = 0;
    drive_in(0, 0, 1, 0, 0); edges(3);
    drive_in(1, 0, 1, 0, 0); edges(2);
    chk("R3 zero window drives", outw(), W_DRV_HI);
    edges(1);
    chk("R4 zero window then hold", outw(), W_HOLD_HI);

    // R10 withdraw from hold and mid-window
    drive_in(0, 0, 1, 0, 0); edges(1);
    chk("R10 drop from hold", outw(), W_IDLE);
    win_len = 8;
    drive_in(1, 0, 1, 0, 0); edges(3);
    chk("R3 long window running", outw(), W_DRV_HI);
    drive_in(0, 0, 1, 0, 0); edges(1);
    chk("R10 drop mid-window", outw(), W_IDLE);

    // R6 handshake timeout boundary
    drive_in(0, 0, 0, 1, 0); edges(3);
    drive_in(1, 0, 0, 1, 0); edges(1023);
    chk("R6 edge 1023 still waiting", outw(), W_WAIT_HI);
    edges(1);
    chk("R6 timeout fault", outw(), W_FAULT);
    drive_in(0, 1, 0, 0, 0); edges(4);
    chk("R7 fault holds across commands", outw(), W_FAULT);
    drive_in(0, 0, 0, 0, 1); edges(1);
    chk("R7 cleared", outw(), W_IDLE);
    fault_clr = 0;

    // R9 level code pass-through
    @(negedge clk); drv_level_in = 3'd5; #1;
    chk("R9 level before edge", drv_level, 0);
    edges(1);
    chk("R9 level after edge", drv_level, 5);
    drive_in(0, 1, 0, 0, 0); edges(2);
    @(negedge clk); drv_level_in = 3'd7; edges(1);
    chk("R9 level during drive", drv_level, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule